// File: doc/BRIEF.md
# ALU Status Flag Register

This block keeps the program status byte of a small 8-bit microcontroller core. After every arithmetic, logic or rotate operation it takes the operands, the ALU result and the carry input that the datapath used, then works out carry, half-carry, zero and overflow and registers them. Addition sets carry and half-carry on a carry out. Subtraction sets them when no borrow occurs. Logic operations touch only the zero flag. Rotate-through-carry operations touch only the carry flag.

Two more bits follow the power state of the core. The power-down flag is set on halt and cleared on a watchdog clear. The time-out flag is set on a watchdog expiry and cleared on a watchdog clear or a halt. Power-up reset clears both. Software may write the byte, but a write reaches only the four ALU flags. The top two bits always read as zero. Nothing here saves or restores the byte around interrupts or calls; firmware must do that itself.

Top module: `alu_status_reg`

## Requirements
- R1: After reset, while `rst_n` is low, `status_o` reads 0x00.
- R2: With `op_sel`=1 (add), bit 0 becomes the carry out of `opnd_a + opnd_b + carry_in`. Bit 1 becomes the carry out of the low-nibble sum `a[3:0] + b[3:0] + carry_in`.
- R3: With `op_sel`=2 (subtract, computed as `a + ~b + carry_in`, so `carry_in`=1 means no borrow in), bit 0 is 1 exactly when no borrow occurs, that is a >= b + (1 - carry_in). Bit 1 is 1 exactly when the low nibble needs no borrow.
- R4: For add and subtract, bit 3 is set when the signed result falls outside -128..127, which is the case when the carry into the top bit differs from the carry out of it.
- R5: For add, subtract and logic operations, bit 2 is 1 exactly when `alu_res` is zero.
- R6: With `op_sel`=3 (logic), bits 0, 1 and 3 keep their values and only bit 2 is updated.
- R7: With `op_sel`=4 (rotate left through carry), bit 0 takes `opnd_a[7]`. With `op_sel`=5 (rotate right through carry), bit 0 takes `opnd_a[0]`. Bits 1 to 3 are unchanged by both.
- R8: Bit 4 (power-down) is set by `halt_evt` and cleared by `wdt_clr_evt`. If both are high in the same cycle, the set wins.
- R9: Bit 5 (time-out) is set by `wdt_tmo_evt` and cleared by `wdt_clr_evt` or `halt_evt`. If a set and a clear fall in the same cycle, the set wins.
- R10: Bits 7 and 6 of `status_o` are always 0.
- R11: `sw_wr_en` loads bits 3:0 from `sw_wr_data[3:0]` and overrides any ALU update in the same cycle. It never changes bits 5:4. Events in the same cycle still apply to bits 5:4.
- R12: With `op_sel`=0, 6 or 7 and no write or event, `status_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| op_sel | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 logic, 4 rotate left, 5 rotate right |
| opnd_a | input | DATA_W | First ALU operand |
| opnd_b | input | DATA_W | Second ALU operand |
| alu_res | input | DATA_W | Result produced by the ALU |
| carry_in | input | 1 | Carry used by the ALU for add and subtract |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 8 | Software write data |
| halt_evt | input | 1 | Halt instruction executed |
| wdt_clr_evt | input | 1 | Watchdog-clear instruction executed |
| wdt_tmo_evt | input | 1 | Watchdog time-out |
| status_o | output | 8 | Packed status byte |

## Verification
The hardest cases to reach are those where several causes land in one cycle: a software write on top of an ALU operation and a power event, or a set and a clear strobe of a power flag together. The bench drives these combinations on purpose and checks which source wins on each bit. For the flag arithmetic, it sweeps every value of the first operand against a stepped set of second operands, with both carry inputs, for add and subtract. This exercises every nibble-borrow and signed-overflow boundary. Logic and rotate operations run after a write that sets all four ALU flags to 1, so that any flag cleared by mistake shows up.

// File: rtl/stflag_pkg.sv
package stflag_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_LOGIC = 3'd3,
        OP_ROTL  = 3'd4,
        OP_ROTR  = 3'd5
    } op_e;

    // packed order matches the bit positions of the status byte (bit 5 down to 0)
    typedef struct packed {
        logic tmo;
        logic pdn;
        logic ovf;
        logic zero;
        logic hcy;
        logic cy;
    } flags_t;

endpackage

// File: rtl/stflag_arith.sv
module stflag_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic              cy_o,
    output logic              hcy_o,
    output logic              ovf_o,
    output logic              zero_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [HALF_W:0]   low_sum;
    logic              cin_msb;

    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
        low_sum  = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin_i};
        cin_msb  = a_i[DATA_W-1] ^ b_eff[DATA_W-1] ^ full_sum[DATA_W-1];
        cy_o     = full_sum[DATA_W];
        hcy_o    = low_sum[HALF_W];
        ovf_o    = cin_msb ^ full_sum[DATA_W];
        zero_o   = (res_i == '0);
    end
endmodule

// File: rtl/stflag_pwr.sv
module stflag_pwr (
    input  logic pdn_i,
    input  logic tmo_i,
    input  logic halt_i,
    input  logic clr_i,
    input  logic expire_i,
    output logic pdn_o,
    output logic tmo_o
);
    always_comb begin
        pdn_o = pdn_i;
        if (halt_i)
            pdn_o = 1'b1;
        else if (clr_i)
            pdn_o = 1'b0;

        tmo_o = tmo_i;
        if (expire_i)
            tmo_o = 1'b1;
        else if (clr_i || halt_i)
            tmo_o = 1'b0;
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import stflag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              carry_in,
    input  logic              sw_wr_en,
    input  logic [7:0]        sw_wr_data,
    input  logic              halt_evt,
    input  logic              wdt_clr_evt,
    input  logic              wdt_tmo_evt,
    output logic [7:0]        status_o
);
    localparam int PAD_W = 8 - $bits(flags_t);

    flags_t flags_d, flags_q;
    logic   a_cy, a_hcy, a_ovf, a_zero;
    logic   p_pdn, p_tmo;
    op_e    op;

    assign op = op_e'(op_sel);

    stflag_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .res_i  (alu_res),
        .cin_i  (carry_in),
        .sub_i  (op == OP_SUB),
        .cy_o   (a_cy),
        .hcy_o  (a_hcy),
        .ovf_o  (a_ovf),
        .zero_o (a_zero)
    );

    stflag_pwr u_pwr (
        .pdn_i    (flags_q.pdn),
        .tmo_i    (flags_q.tmo),
        .halt_i   (halt_evt),
        .clr_i    (wdt_clr_evt),
        .expire_i (wdt_tmo_evt),
        .pdn_o    (p_pdn),
        .tmo_o    (p_tmo)
    );

    always_comb begin
        flags_d = flags_q;
        case (op)
            OP_ADD, OP_SUB: begin
                flags_d.cy   = a_cy;
                flags_d.hcy  = a_hcy;
                flags_d.ovf  = a_ovf;
                flags_d.zero = a_zero;
            end
            OP_LOGIC: flags_d.zero = a_zero;
            OP_ROTL:  flags_d.cy   = opnd_a[DATA_W-1];
            OP_ROTR:  flags_d.cy   = opnd_a[0];
            default:  ;
        endcase
        if (sw_wr_en) begin
            flags_d.cy   = sw_wr_data[0];
            flags_d.hcy  = sw_wr_data[1];
            flags_d.zero = sw_wr_data[2];
            flags_d.ovf  = sw_wr_data[3];
        end
        flags_d.pdn = p_pdn;
        flags_d.tmo = p_tmo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign status_o = {{PAD_W{1'b0}}, flags_q};
endmodule

// File: rtl/stflag_chk.sv
module stflag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_sel,
    input logic       sw_wr_en,
    input logic       halt_evt,
    input logic       wdt_clr_evt,
    input logic       wdt_tmo_evt,
    input logic [7:0] status_o
);
    logic no_evt;
    assign no_evt = !halt_evt && !wdt_clr_evt && !wdt_tmo_evt;

    // R10
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == 2'b00);

    // R11
    wr_keeps_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && no_evt) |=> status_o[5:4] == $past(status_o[5:4]));

    // R6
    logic_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3 && !sw_wr_en) |=>
        (status_o[3] == $past(status_o[3]) && status_o[1:0] == $past(status_o[1:0])));

    // R9
    tmo_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo_evt |=> status_o[5]);

    // R8
    halt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |=> status_o[4]);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 3'd0 || op_sel[2:1] == 2'b11) && !sw_wr_en && no_evt)
        |=> $stable(status_o));
endmodule

bind alu_status_reg stflag_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sel      (op_sel),
    .sw_wr_en    (sw_wr_en),
    .halt_evt    (halt_evt),
    .wdt_clr_evt (wdt_clr_evt),
    .wdt_tmo_evt (wdt_tmo_evt),
    .status_o    (status_o)
);

// File: tb/sim_alu_status_reg.sv
`timescale 1ns/1ps
module sim_alu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic       carry_in = 1'b0, sw_wr_en = 1'b0;
    logic [7:0] sw_wr_data = '0;
    logic       halt_evt = 1'b0, wdt_clr_evt = 1'b0, wdt_tmo_evt = 1'b0;
    logic [7:0] status_o;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_st = 8'h00;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu_status_reg u0 (.*);

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic logic [7:0] model(logic [7:0] cur, int op, int a, int b, int res,
                                         int cin, bit wr, logic [7:0] wd, bit h, bit c, bit t);
        logic [7:0] n = cur;
        int s, bw;
        case (op)
            1: begin
                n[0] = (a + b + cin) > 255;
                n[1] = ((a % 16) + (b % 16) + cin) > 15;
                s = sgn(a) + sgn(b) + cin;
                n[3] = (s > 127) || (s < -128);
                n[2] = (res == 0);
            end
            2: begin
                bw = 1 - cin;
                n[0] = a >= b + bw;
                n[1] = (a % 16) >= (b % 16) + bw;
                s = sgn(a) - sgn(b) - bw;
                n[3] = (s > 127) || (s < -128);
                n[2] = (res == 0);
            end
            3: n[2] = (res == 0);
            4: n[0] = a[7];
            5: n[0] = a[0];
            default: ;
        endcase
        if (wr) n[3:0] = wd[3:0];
        if (h) n[4] = 1'b1; else if (c) n[4] = 1'b0;
        if (t) n[5] = 1'b1; else if (c || h) n[5] = 1'b0;
        n[7:6] = 2'b00;
        return n;
    endfunction

    task automatic step(string tag, int op, int a, int b, int res, int cin,
                        bit wr, logic [7:0] wd, bit h, bit c, bit t);
        exp_st = model(exp_st, op, a, b, res, cin, wr, wd, h, c, t);
        op_sel = 3'(op); opnd_a = 8'(a); opnd_b = 8'(b); alu_res = 8'(res);
        carry_in = 1'(cin); sw_wr_en = wr; sw_wr_data = wd;
        halt_evt = h; wdt_clr_evt = c; wdt_tmo_evt = t;
        @(negedge clk);
        n_cmp++;
        if (status_o !== exp_st) begin
            n_bad++;
            $display("FAIL %s: op=%0d a=%0d b=%0d cin=%0d actual=%02h expected=%02h",
                     tag, op, a, b, cin, status_o, exp_st);
        end
    endtask

    task automatic idle();
        op_sel = '0; sw_wr_en = 0; halt_evt = 0; wdt_clr_evt = 0; wdt_tmo_evt = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 R10: reset value
        n_cmp++;
        if (status_o !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: actual=%02h expected=00", status_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5: add sweep
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
                for (int cin = 0; cin < 2; cin++)
                    step("R2/R4/R5 add", 1, a, b, (a + b + cin) % 256, cin, 0, 0, 0, 0, 0);

        // R3 R4 R5: subtract sweep
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
                for (int cin = 0; cin < 2; cin++)
                    step("R3/R4/R5 sub", 2, a, b, (a - b - 1 + cin + 512) % 256, cin, 0, 0, 0, 0, 0);

        // R6 R5: logic keeps C/AC/OV
        step("R11 write ones", 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
        step("R6 logic zero", 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6 logic nonzero", 3, 0, 0, 8'h5A, 0, 0, 0, 0, 0, 0);
        step("R11 write zeros", 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0);
        step("R6 logic zero from clear", 3, 9, 9, 0, 1, 0, 0, 0, 0, 0);

        // R7: rotate through carry
        step("R11 write ones", 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
        for (int a = 0; a < 256; a += 3) begin
            step("R7 rotl", 4, a, 0, 0, 0, 0, 0, 0, 0, 0);
            step("R7 rotr", 5, a, 0, 0, 0, 0, 0, 0, 0, 0);
        end

        // R8 R9: power flags
        step("R8 halt", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R9 timeout", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R8/R9 clear", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R9 timeout", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R9 halt clears TO", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R8 clear", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R8 halt beats clear", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        step("R9 timeout beats clear+halt", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);

        // R11: software write
        step("R11 write cannot clear PD/TO", 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0);
        step("R11 clear", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R11 write cannot set PD/TO", 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
        step("R11 write beats add", 1, 255, 1, 0, 0, 1, 8'h00, 0, 0, 0);
        step("R11 write with halt", 0, 0, 0, 0, 0, 1, 8'h0A, 1, 0, 0);
        step("R11 write with timeout", 2, 0, 1, 255, 1, 1, 8'hC5, 0, 0, 1);

        // R12: idle codes hold
        step("R12 op0 hold", 0, 255, 255, 0, 1, 0, 0, 0, 0, 0);
        step("R12 op6 hold", 6, 255, 255, 0, 1, 0, 0, 0, 0, 0);
        step("R12 op7 hold", 7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle();
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule